// File: doc/BRIEF.md
# Triple-Redundant Register with Per-Copy Fault Injection

This block holds a word of state in three independent copies and drives its output from a bitwise two-of-three vote across them. A single corrupted copy therefore never reaches the output. Every copy takes a new value from the data input on every rising clock edge. The copies have no enable.

Each copy has its own injection bit. When that bit is high at a clock edge, the copy stores the bitwise inverse of the data input for that cycle only. A test can use this to corrupt one, two or all three copies on purpose and then watch the voted output. A disagreement flag goes high whenever the copies do not all hold the same word. This shows that the voter is masking a fault, as opposed to there being no fault at all.

Top module: `tmr_reg`

## Requirements
- R1: A synchronous active-high reset loads every copy with the reset value, which is all zeros by default. In the cycle after reset, `q_out` equals that value and `mismatch` is 0, whatever `d_in` and `inj_mask` were during reset.
- R2: With `inj_mask` = 3'b000 at a clock edge, `q_out` after that edge equals the `d_in` sampled at that edge. This is a latency of one cycle.
- R3: With exactly one bit of `inj_mask` set at an edge, `q_out` after that edge still equals the sampled `d_in`. Bit 0 selects copy 0, bit 1 selects copy 1 and bit 2 selects copy 2.
- R4: With exactly two bits of `inj_mask` set at an edge, `q_out` after that edge equals the bitwise inverse of the sampled `d_in`, because the wrong value has the majority.
- R5: With all three bits of `inj_mask` set, `q_out` equals the inverse of the sampled `d_in`, and `mismatch` stays 0 because the copies agree.
- R6: `mismatch` is 1 exactly when the stored copies are not all equal. After an edge with one or two injection bits set, it is 1. After an edge with zero or three bits set, it is 0.
- R7: An injected fault lasts one cycle only. After the next edge with `inj_mask` = 0, `q_out` follows `d_in` again and `mismatch` returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| d_in | input | WIDTH | Data word captured by all three copies |
| inj_mask | input | 3 | Per-copy injection; a set bit inverts that copy's captured word |
| q_out | output | WIDTH | Bitwise majority of the three copies |
| mismatch | output | 1 | High when the three copies are not identical |

## Verification
The main stimulus walks each of the eight injection masks across several data words. The clean mask shows plain one-cycle capture. Each single-copy mask separately shows that the vote masks a fault in that particular copy. The two-copy masks show that the output follows the majority even when the majority is wrong. The all-copies mask separates "the copies disagree" from "the output is wrong", since here the output is inverted while the flag stays low. Directed cases cover reset overriding injection, reset in the middle of a run, and a fault that clears in the cycle after injection stops.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int COPIES = 3;

    typedef logic [COPIES-1:0] inj_t;

    // Two-of-three majority on one bit.
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    // High when the three bits are not all the same.
    function automatic logic differ3(input logic a, input logic b, input logic c);
        return (a ^ b) | (b ^ c);
    endfunction

endpackage

// File: rtl/tmr_cell.sv
module tmr_cell #(
    parameter int              WIDTH     = 8,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    input  logic             flip,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] flip_word;

    assign flip_word = {WIDTH{flip}};

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RESET_VAL;
        end else begin
            q <= d ^ flip_word;
        end
    end

endmodule

// File: rtl/tmr_voter.sv
module tmr_voter #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [WIDTH-1:0] c,
    output logic [WIDTH-1:0] voted,
    output logic [WIDTH-1:0] disagree
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign voted[i]    = tmr_pkg::maj3(a[i], b[i], c[i]);
        assign disagree[i] = tmr_pkg::differ3(a[i], b[i], c[i]);
    end

endmodule

// File: rtl/tmr_reg.sv
module tmr_reg #(
    parameter int               WIDTH     = 8,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    input  logic [2:0]       inj_mask,
    output logic [WIDTH-1:0] q_out,
    output logic             mismatch
);

    import tmr_pkg::*;

    logic [WIDTH-1:0] copy_q [COPIES];
    logic [WIDTH-1:0] disagree;

    for (genvar k = 0; k < COPIES; k++) begin : g_copy
        tmr_cell #(
            .WIDTH     (WIDTH),
            .RESET_VAL (RESET_VAL)
        ) u_cell (
            .clk  (clk),
            .rst  (rst),
            .d    (d_in),
            .flip (inj_mask[k]),
            .q    (copy_q[k])
        );
    end

    tmr_voter #(.WIDTH(WIDTH)) u_voter (
        .a        (copy_q[0]),
        .b        (copy_q[1]),
        .c        (copy_q[2]),
        .voted    (q_out),
        .disagree (disagree)
    );

    assign mismatch = |disagree;

    // R1: reset dominates injection
    p_reset_clean_r1: assert property (@(posedge clk)
        rst |=> (q_out == RESET_VAL) && !mismatch);

    // R2: clean capture, one cycle latency
    p_clean_follow_r2: assert property (@(posedge clk) disable iff (rst)
        (inj_mask == 3'b000) |=> (q_out == $past(d_in)));

    // R3: a single faulted copy is outvoted
    p_single_masked_r3: assert property (@(posedge clk) disable iff (rst)
        ($countones(inj_mask) == 1) |=> (q_out == $past(d_in)));

    // R4 / R5: a faulted majority wins
    p_majority_wrong_r4: assert property (@(posedge clk) disable iff (rst)
        ($countones(inj_mask) >= 2) |=> (q_out == ~$past(d_in)));

    // R6: flag set on partial injection
    p_flag_partial_r6: assert property (@(posedge clk) disable iff (rst)
        (($countones(inj_mask) == 1) || ($countones(inj_mask) == 2)) |=> mismatch);

    // R6 / R5 / R7: flag clear when copies agree
    p_flag_agree_r6: assert property (@(posedge clk) disable iff (rst)
        ((inj_mask == 3'b000) || (inj_mask == 3'b111)) |=> !mismatch);

endmodule

// File: tb/tmr_reg_bench.sv
`timescale 1ns/1ps
module tmr_reg_bench;

    localparam int WIDTH = 8;
    localparam int NVEC  = 12;

    // {d_in, inj_mask, expected q_out, expected mismatch}
    localparam logic [19:0] VEC [NVEC] = '{
        {8'hA5, 3'b000, 8'hA5, 1'b0},   // R2
        {8'h3C, 3'b001, 8'h3C, 1'b1},   // R3 copy 0
        {8'h3C, 3'b010, 8'h3C, 1'b1},   // R3 copy 1
        {8'h3C, 3'b100, 8'h3C, 1'b1},   // R3 copy 2
        {8'hF0, 3'b011, 8'h0F, 1'b1},   // R4
        {8'hF0, 3'b101, 8'h0F, 1'b1},   // R4
        {8'hF0, 3'b110, 8'h0F, 1'b1},   // R4
        {8'h96, 3'b111, 8'h69, 1'b0},   // R5
        {8'h96, 3'b000, 8'h96, 1'b0},   // R7
        {8'h00, 3'b001, 8'h00, 1'b1},   // R3
        {8'hFF, 3'b010, 8'hFF, 1'b1},   // R3
        {8'h55, 3'b000, 8'h55, 1'b0}    // R7
    };

    logic             clk = 1'b0;
    logic             rst;
    logic [WIDTH-1:0] d_in;
    logic [2:0]       inj_mask;
    logic [WIDTH-1:0] q_out;
    logic             mismatch;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    tmr_reg #(.WIDTH(WIDTH)) u_tmr_reg (
        .clk      (clk),
        .rst      (rst),
        .d_in     (d_in),
        .inj_mask (inj_mask),
        .q_out    (q_out),
        .mismatch (mismatch)
    );

    task automatic check(input string req, input logic [WIDTH-1:0] exp_q,
                         input logic exp_mm);
        checks++;
        if (q_out !== exp_q || mismatch !== exp_mm) begin
            errors++;
            $display("FAIL %s: q_out=%h mismatch=%b expected q_out=%h mismatch=%b",
                     req, q_out, mismatch, exp_q, exp_mm);
        end
    endtask

    // drive at negedge, one rising edge, sample at the following negedge
    task automatic step(input logic r, input logic [WIDTH-1:0] d, input logic [2:0] m);
        rst = r; d_in = d; inj_mask = m;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; d_in = '1; inj_mask = 3'b111;
        @(negedge clk);
        step(1'b1, 8'hFF, 3'b111);
        check("R1 reset overrides injection", 8'h00, 1'b0);

        for (int i = 0; i < NVEC; i++) begin
            step(1'b0, VEC[i][19:12], VEC[i][11:9]);
            check($sformatf("R2-R7 vector %0d", i), VEC[i][8:1], VEC[i][0]);
        end

        // R7: fault then recovery with the same data
        step(1'b0, 8'h81, 3'b110);
        check("R4 fault before recovery", 8'h7E, 1'b1);
        step(1'b0, 8'h81, 3'b000);
        check("R7 fault cleared", 8'h81, 1'b0);

        // R6: single fault, flag, then cleared
        step(1'b0, 8'hC3, 3'b100);
        check("R6 single fault flagged", 8'hC3, 1'b1);
        step(1'b0, 8'hC3, 3'b000);
        check("R7 flag drops", 8'hC3, 1'b0);

        // R1: reset mid-run while copies disagree
        step(1'b0, 8'h5A, 3'b001);
        check("R3 before mid-run reset", 8'h5A, 1'b1);
        step(1'b1, 8'h5A, 3'b011);
        check("R1 mid-run reset", 8'h00, 1'b0);
        step(1'b0, 8'h12, 3'b000);
        check("R2 after reset", 8'h12, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule